// File: doc/BRIEF.md
# Decimal Second-Order Difference Tabulator

This block produces successive entries of a second-order polynomial using nothing but repeated addition. Three seed values are loaded: the function value of the starting entry, the first difference that led to it, and the constant second difference. Each advance request then produces the next table entry. All three registers hold packed BCD digits, and all arithmetic goes through a single decimal adder.

Each step takes two add phases. In the first phase the running first difference is increased by the second difference. In the second phase the function value is increased by the updated first difference. When the second phase completes, the new entry and its index are presented together with a one-cycle valid pulse. A carry out of the top digit in either phase sets a sticky overflow flag, and the result wraps modulo 10^DIGITS.

Seeding the function value with 41, the first difference with 0 and the second difference with 2 produces n² + n + 41. The first difference register then holds 2n after step n.

Top module: `diffeng_tabulator`

## Requirements
- R1: While reset is asserted, and after it is released, value_o, index_o, valid_o and ovf_o are all zero, and the internal first difference is zero.
- R2: A load_i sampled high at a clock edge has the following effects at that edge. It captures seed_f_i as the function value and seed_d1_i as the first difference. It captures seed_d2_i as the second difference. It clears index_o and ovf_o, keeps valid_o low, and takes priority over advance. It abandons any step in progress without producing a valid pulse.
- R3: An adv_i sampled high at edge k while no step is in progress starts a step. At edge k+1 the first difference becomes first difference + second difference. At edge k+2 value_o becomes function value + new first difference. valid_o is high for exactly the one cycle that follows edge k+2.
- R4: adv_i sampled at edges k+1 and k+2 of a step in progress is ignored. A held adv_i therefore starts a new step every third edge.
- R5: Every value is DIGITS packed BCD digits. Digit i occupies bits 4i+3..4i, and the least significant digit sits at bits 3..0. Each digit adds with a carry in; a digit sum above 9 is corrected by adding 6 and carries into the next digit. The result is the decimal sum modulo 10^DIGITS.
- R6: With seeds 41, 0 and 2, value_o reads 41 after the load. The four following steps give 43, 47, 53 and 61.
- R7: A carry out of the most significant digit in either phase sets ovf_o from the edge of that add onward. The stored result wraps. ovf_o stays set until a load clears it.
- R8: index_o increases by one, modulo 2^IDX_W, at the same edge that updates value_o for a step.
- R9: value_o changes only at a load edge or at the final edge of a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Seed capture strobe |
| seed_f_i | input | 4*DIGITS | Starting function value, packed BCD |
| seed_d1_i | input | 4*DIGITS | First difference that leads to the starting value, packed BCD |
| seed_d2_i | input | 4*DIGITS | Constant second difference, packed BCD |
| adv_i | input | 1 | Request for the next table entry |
| value_o | output | 4*DIGITS | Current function value, packed BCD |
| index_o | output | IDX_W | Index n of the current entry |
| valid_o | output | 1 | One-cycle pulse when a new entry appears |
| ovf_o | output | 1 | Sticky decimal overflow flag |

## Verification
The bench drives a run where carries ripple through every digit position at once. A binary adder, or one that skips the correction by 6, would show hexadecimal digits there. A separate step wraps the function value past the top digit. It then checks that the overflow flag stays set across a further step and clears only on load; a flag that is not sticky, or that is not cleared, shows up immediately. A held advance checks that requests are refused during both phases; a sequencer that accepts them would double the step count. A load placed in the middle of a step must leave the new seed on the output with no valid pulse. A design that lets the pending function update finish would corrupt the seed.

// File: rtl/diffeng_pkg.sv
package diffeng_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DIFF = 2'd1,
      PH_FUNC = 2'd2
   } step_phase_e;

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add (
   input  logic [3:0] a_i,
   input  logic [3:0] b_i,
   input  logic       c_i,
   output logic [3:0] s_o,
   output logic       c_o
);
   logic [4:0] raw;
   logic [4:0] fixed;

   always_comb begin
      raw   = {1'b0, a_i} + {1'b0, b_i} + {4'd0, c_i};
      fixed = raw + 5'd6;
      c_o   = (raw > 5'd9);
      s_o   = c_o ? fixed[3:0] : raw[3:0];
   end
endmodule

// File: rtl/bcd_word_add.sv
module bcd_word_add #(
   parameter int DIGITS = 8,
   localparam int W = 4 * DIGITS
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] s_o,
   output logic         c_o
);
   logic [DIGITS:0] chain;

   assign chain[0] = 1'b0;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      bcd_digit_add u_dig (
         .a_i (a_i[4*g +: 4]),
         .b_i (b_i[4*g +: 4]),
         .c_i (chain[g]),
         .s_o (s_o[4*g +: 4]),
         .c_o (chain[g+1])
      );
   end

   assign c_o = chain[DIGITS];
endmodule

// File: rtl/diffeng_seq.sv
module diffeng_seq
   import diffeng_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic adv_i,
   output logic upd_diff_o,
   output logic upd_func_o
);
   step_phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (load_i) begin
         phase_q <= PH_IDLE;
      end else begin
         case (phase_q)
            PH_IDLE: if (adv_i) phase_q <= PH_DIFF;
            PH_DIFF: phase_q <= PH_FUNC;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign upd_diff_o = (phase_q == PH_DIFF);
   assign upd_func_o = (phase_q == PH_FUNC);

   // R4: once a step has started, it runs to completion without regard to adv_i
   assert_diff_then_func_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DIFF && !load_i) |=> (phase_q == PH_FUNC));
   assert_func_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FUNC && !load_i) |=> (phase_q == PH_IDLE));
   assert_load_aborts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/diffeng_tabulator.sv
module diffeng_tabulator #(
   parameter int DIGITS = 8,
   parameter int IDX_W  = 16,
   localparam int W = 4 * DIGITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [W-1:0]     seed_f_i,
   input  logic [W-1:0]     seed_d1_i,
   input  logic [W-1:0]     seed_d2_i,
   input  logic             adv_i,
   output logic [W-1:0]     value_o,
   output logic [IDX_W-1:0] index_o,
   output logic             valid_o,
   output logic             ovf_o
);
   if (DIGITS < 1 || DIGITS > 16) begin : g_bad_digits
      $error("DIGITS must lie in 1..16");
   end
   if (IDX_W < 2 || IDX_W > 32) begin : g_bad_index
      $error("IDX_W must lie in 2..32");
   end

   logic [W-1:0]     f_q, d1_q, d2_q;
   logic [IDX_W-1:0] n_q;
   logic             valid_q, ovf_q;
   logic             upd_diff, upd_func;
   logic [W-1:0]     op_a, op_b, sum;
   logic             carry;

   diffeng_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .adv_i      (adv_i),
      .upd_diff_o (upd_diff),
      .upd_func_o (upd_func)
   );

   // the one shared adder: difference phase, then function phase
   always_comb begin
      op_a = upd_func ? f_q  : d1_q;
      op_b = upd_func ? d1_q : d2_q;
   end

   bcd_word_add #(.DIGITS(DIGITS)) u_add (
      .a_i (op_a),
      .b_i (op_b),
      .s_o (sum),
      .c_o (carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q     <= '0;
         d1_q    <= '0;
         d2_q    <= '0;
         n_q     <= '0;
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (load_i) begin
            f_q   <= seed_f_i;
            d1_q  <= seed_d1_i;
            d2_q  <= seed_d2_i;
            n_q   <= '0;
            ovf_q <= 1'b0;
         end else begin
            if (upd_diff) begin
               d1_q <= sum;
               if (carry) ovf_q <= 1'b1;
            end
            if (upd_func) begin
               f_q     <= sum;
               n_q     <= n_q + 1'b1;
               valid_q <= 1'b1;
               if (carry) ovf_q <= 1'b1;
            end
         end
      end
   end

   assign value_o = f_q;
   assign index_o = n_q;
   assign valid_o = valid_q;
   assign ovf_o   = ovf_q;

   assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   assert_index_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (index_o == IDX_W'($past(index_o) + 1'b1)));
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !load_i) |=> ovf_o);
   assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!ovf_o && index_o == '0 && !valid_o));
   assert_value_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value_o) |-> (valid_o || $past(load_i)));
endmodule

// File: tb/diffeng_tabulator_test.sv
module diffeng_tabulator_test;
   localparam int DIGITS = 8;
   localparam int IDX_W  = 16;
   localparam int W      = 4 * DIGITS;
   localparam longint MODV = 64'd100000000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_i = 1'b0;
   logic [W-1:0]     seed_f_i = '0, seed_d1_i = '0, seed_d2_i = '0;
   logic             adv_i = 1'b0;
   logic [W-1:0]     value_o;
   logic [IDX_W-1:0] index_o;
   logic             valid_o, ovf_o;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   diffeng_tabulator #(.DIGITS(DIGITS), .IDX_W(IDX_W)) uut (
      .clk, .rst_n, .load_i, .seed_f_i, .seed_d1_i, .seed_d2_i,
      .adv_i, .value_o, .index_o, .valid_o, .ovf_o
   );

   always #4 clk = ~clk;

   function automatic longint bcd2int(logic [W-1:0] v);
      longint r = 0;
      for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
      return r;
   endfunction

   function automatic logic [W-1:0] int2bcd(longint x);
      logic [W-1:0] v = '0;
      for (int i = 0; i < DIGITS; i++) begin
         v[4*i +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return v;
   endfunction

   // behavioural reference model
   longint mf = 0, md1 = 0, md2 = 0, s;
   int     mn = 0, mph = 0;
   bit     mvalid = 0, movf = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         mf = 0; md1 = 0; md2 = 0; mn = 0; mph = 0; mvalid = 0; movf = 0;
      end else begin
         mvalid = 0;
         if (load_i) begin
            mf = bcd2int(seed_f_i); md1 = bcd2int(seed_d1_i); md2 = bcd2int(seed_d2_i);
            mn = 0; movf = 0; mph = 0;
         end else if (mph == 0) begin
            if (adv_i) mph = 1;
         end else if (mph == 1) begin
            s = md1 + md2;
            if (s >= MODV) movf = 1;
            md1 = s % MODV;
            mph = 2;
         end else begin
            s = mf + md1;
            if (s >= MODV) movf = 1;
            mf = s % MODV;
            mn = (mn + 1) % (1 << IDX_W);
            mvalid = 1;
            mph = 0;
         end
      end
   end

   task automatic chk(string tag, string what, longint act, longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      chk("R5", "value_o", longint'(value_o), longint'(int2bcd(mf)));
      chk("R8", "index_o", longint'(index_o), longint'(mn));
      chk("R3", "valid_o", longint'(valid_o), longint'(mvalid));
      chk("R7", "ovf_o",   longint'(ovf_o),   longint'(movf));
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic do_load(logic [W-1:0] f, logic [W-1:0] d1, logic [W-1:0] d2);
      @(negedge clk);
      seed_f_i = f; seed_d1_i = d1; seed_d2_i = d2; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   // one advance; returns at the negedge where valid_o should be high
   task automatic do_step();
      @(negedge clk); adv_i = 1'b1;
      @(negedge clk); adv_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [IDX_W-1:0] idx0;
      repeat (3) @(negedge clk);
      chk("R1", "reset value", longint'(value_o), 0);
      chk("R1", "reset flags", longint'({index_o, valid_o, ovf_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "after release", longint'({value_o, valid_o, ovf_o}), 0);

      // reference polynomial
      do_load(32'h41, 32'h0, 32'h2);
      chk("R2", "seed on output", longint'(value_o), longint'(32'h41));
      chk("R6", "n=0 index", longint'(index_o), 0);
      do_step();
      chk("R6", "f(1)", longint'(value_o), longint'(32'h43));
      chk("R3", "valid pulse", longint'(valid_o), 1);
      @(negedge clk);
      chk("R3", "valid one cycle", longint'(valid_o), 0);
      do_step(); chk("R6", "f(2)", longint'(value_o), longint'(32'h47));
      do_step(); chk("R6", "f(3)", longint'(value_o), longint'(32'h53));
      do_step(); chk("R6", "f(4)", longint'(value_o), longint'(32'h61));
      chk("R8", "index 4", longint'(index_o), 4);

      // adv held across a step: only one step
      idx0 = index_o;
      @(negedge clk); adv_i = 1'b1;
      repeat (3) @(negedge clk);
      adv_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R4", "held adv single step", longint'(index_o), longint'(idx0) + 1);
      chk("R4", "held adv value", longint'(value_o), longint'(32'h71));

      // held adv for many edges: a step every third edge
      idx0 = index_o;
      @(negedge clk); adv_i = 1'b1;
      repeat (9) @(negedge clk);
      adv_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R4", "held adv cadence", longint'(index_o), longint'(idx0) + 3);

      // ripple carry through digits
      do_load(32'h00000999, 32'h0, 32'h1);
      do_step();
      chk("R5", "decimal ripple", longint'(value_o), longint'(32'h00001000));
      do_load(32'h09999999, 32'h0, 32'h1);
      do_step();
      chk("R5", "full ripple", longint'(value_o), longint'(32'h10000000));
      chk("R7", "no overflow", longint'(ovf_o), 0);

      // overflow in function phase, sticky
      do_load(32'h99999990, 32'h5, 32'h5);
      do_step();
      chk("R7", "wrapped value", longint'(value_o), 0);
      chk("R7", "overflow set", longint'(ovf_o), 1);
      do_step();
      chk("R7", "overflow sticky", longint'(ovf_o), 1);
      chk("R5", "after wrap", longint'(value_o), longint'(32'h15));
      do_load(32'h12, 32'h0, 32'h0);
      chk("R2", "load clears ovf", longint'(ovf_o), 0);

      // overflow in difference phase
      do_load(32'h100, 32'h99999999, 32'h1);
      do_step();
      chk("R7", "diff wrap ovf", longint'(ovf_o), 1);
      chk("R7", "diff wrap value", longint'(value_o), longint'(32'h100));

      // load in the middle of a step aborts it
      do_load(32'h500, 32'h3, 32'h1);
      @(negedge clk); adv_i = 1'b1;
      @(negedge clk); adv_i = 1'b0;
      seed_f_i = 32'h777; seed_d1_i = 32'h0; seed_d2_i = 32'h0; load_i = 1'b1;
      @(negedge clk); load_i = 1'b0;
      chk("R2", "abort seed", longint'(value_o), longint'(32'h777));
      @(negedge clk);
      chk("R2", "abort no valid", longint'(valid_o), 0);
      chk("R9", "abort value held", longint'(value_o), longint'(32'h777));
      chk("R8", "abort index", longint'(index_o), 0);

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule